// File: doc/BRIEF.md
# Stop-Bit Rate Adapter

This block takes a start/stop framed serial character stream whose bit rate may drift a little from nominal. It re-times the stream onto an exact output bit rate of either 1200 or 600 bit/s. The system clock carries a tick enable at sixteen times the 1200 bit/s rate, and every timing decision is made from that tick. Received characters pass through a two-entry buffer. The transmit side then rebuilds each frame at the exact rate.

The rate mismatch is absorbed in whole stop bits. If the input runs slow, the output simply idles as marks between characters, which adds stop bits. If the input runs fast and the next character is already waiting when the current stop bit is due, that stop bit is dropped. A deletion is allowed at most once in any eight characters, and only when the stop bit was received as 1.

A break is an input held low through a whole character, including its start and stop positions. It is re-sent as a low run of 2N+3 bit times, where N is the total number of bits per character. In bypass mode the converter steps aside, and the line level is copied to the output at each bit strobe.

Top module: `async_sync_rate_conv`

## Requirements
- R1: `bit_stb` pulses once every 16 `os_tick` pulses when `rate_600` is 0, and once every 32 when it is 1, counted from reset. `tx_bit` changes only in the cycle in which `bit_stb` is 1.
- R2: After reset, `tx_bit` is 1 and `bit_stb` is 0 until the first full bit period has elapsed. Whenever no character is pending, the output carries marks (1).
- R3: A falling edge starts a character only if the line is still low at the tick half a bit later. A low pulse shorter than that produces no output character.
- R4: The total number of bits per character is N = 8 + `char_len`, so `char_len` 0 to 3 gives 8 to 11. Each output frame is a start bit (0), then N-2 data bits with the least significant bit first, then a stop bit (1).
- R5: For input bit rates between 2.5% below and 1.0% above nominal, every character is delivered once, in order, with its data intact.
- R6: When the input runs slow, extra mark bits appear between output characters.
- R7: A stop bit is dropped only under three conditions: another character is already buffered when the stop bit is due, the stop bit was received as 1, and at least seven characters have been completed since the previous drop. The next start bit then follows the last data bit directly.
- R8: A received character whose data bits and stop position are all 0 is a break. It is sent as exactly 2N+3 low bits followed by a mark. After a break, the receiver waits for the line to return high before it looks for a new start bit.
- R9: With `bypass` at 1, `tx_bit` takes the synchronised line level at each `bit_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit at 1200 bit/s |
| rxd_in | input | 1 | Asynchronous serial input line |
| rate_600 | input | 1 | 0 selects 1200 bit/s, 1 selects 600 bit/s |
| char_len | input | 2 | Character length code, N = 8 + code |
| bypass | input | 1 | 1 copies the line straight to the output |
| tx_bit | output | 1 | Re-timed serial output bit |
| bit_stb | output | 1 | One-cycle pulse at the start of each output bit |

## Verification
The bench sends back-to-back characters at nominal, +1% and -2.5% rates with three different character lengths, plus one stream at 600 bit/s. It decodes the output and compares each character with the one sent. A design that drifted its strobe, lost a buffered character or dropped stop bits too often would show a bad period, a missing character, or two deletions closer than eight characters apart. Several corner cases get their own stimulus: a short low glitch, a one-character break followed by a normal character, and a bypass pattern. A receiver that failed to wait for the line to go high after a break would emit a spurious extra character. A break that was not stretched would show a low run shorter than 2N+3.

// File: rtl/async_sync_rate_conv.sv
module async_sync_rate_conv #(
  parameter int OSR     = 16,
  parameter int DEL_WIN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd_in,
  input  logic       rate_600,
  input  logic [1:0] char_len,
  input  logic       bypass,
  output logic       tx_bit,
  output logic       bit_stb
);
  localparam int TW = $clog2(OSR);
  localparam int GW = $clog2(DEL_WIN);
  localparam logic [TW-1:0] TMAX  = TW'(OSR - 1);
  localparam logic [TW-1:0] THALF = TW'(OSR / 2 - 1);
  localparam logic [GW-1:0] GMAX  = GW'(DEL_WIN - 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_HOLD} rx_state_t;

  logic [1:0] sync;
  logic       half;
  wire        rx  = sync[1];
  wire        ten = os_tick & (~rate_600 | half);

  wire [3:0] nbits = 4'd8 + {2'b00, char_len};
  wire [3:0] ndata = nbits - 4'd2;
  wire [4:0] n5    = {1'b0, nbits};

  rx_state_t     rs;
  logic [TW-1:0] rtk;
  logic [3:0]    ridx;
  logic [8:0]    rdat;
  logic          push;
  logic [10:0]   push_ent;

  logic [10:0] mem [2];
  logic        wp, rp;
  logic [1:0]  cnt;
  logic        pop;
  wire         wr_ok = push && (cnt != 2'd2);
  wire [10:0]  head  = mem[rp];

  logic [TW-1:0] tcnt;
  logic [4:0]    left;
  logic [8:0]    shreg;
  logic          cur_ok;
  logic [GW-1:0] since;
  wire           stb  = ten && (tcnt == TMAX);
  wire           have = (cnt != 2'd0);
  wire           del  = stb && !bypass && (left == 5'd1) && have && cur_ok && (since == GMAX);
  assign pop = stb && !bypass && have && ((left == 5'd0) || del);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11;
      half <= 1'b0;
    end else begin
      sync <= {sync[0], rxd_in};
      if (os_tick) half <= ~half;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs       <= R_IDLE;
      rtk      <= '0;
      ridx     <= '0;
      rdat     <= '0;
      push     <= 1'b0;
      push_ent <= '0;
    end else begin
      push <= 1'b0;
      if (ten) begin
        case (rs)
          R_IDLE: if (!rx) begin rs <= R_START; rtk <= '0; end
          R_START: begin
            rtk <= rtk + 1'b1;
            if (rtk == THALF) begin
              if (!rx) begin
                rs   <= R_DATA;
                rtk  <= '0;
                ridx <= '0;
                rdat <= '0;
              end else rs <= R_IDLE;
            end
          end
          R_DATA: begin
            rtk <= (rtk == TMAX) ? '0 : rtk + 1'b1;
            if (rtk == TMAX) begin
              if (ridx < ndata) begin
                rdat[ridx] <= rx;
                ridx       <= ridx + 4'd1;
              end else begin
                push     <= 1'b1;
                push_ent <= {(rdat == 9'd0) && !rx, rx, rdat};
                rs       <= rx ? R_IDLE : R_HOLD;
              end
            end
          end
          R_HOLD: if (rx) rs <= R_IDLE;
          default: rs <= R_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= 1'b0;
      rp  <= 1'b0;
      cnt <= 2'd0;
    end else begin
      if (wr_ok) begin
        mem[wp] <= push_ent;
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      cnt <= cnt + {1'b0, wr_ok} - {1'b0, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt    <= '0;
      left    <= '0;
      shreg   <= '0;
      cur_ok  <= 1'b0;
      since   <= GMAX;
      tx_bit  <= 1'b1;
      bit_stb <= 1'b0;
    end else begin
      bit_stb <= stb;
      if (ten) tcnt <= (tcnt == TMAX) ? '0 : tcnt + 1'b1;
      if (stb) begin
        if (bypass) begin
          tx_bit <= rx;
          left   <= '0;
        end else if (pop) begin
          tx_bit <= 1'b0;
          shreg  <= head[8:0];
          cur_ok <= head[9];
          left   <= head[10] ? (n5 << 1) + 5'd3 : n5 - 5'd1;
          if (del) since <= '0;
        end else if (left == 5'd1) begin
          tx_bit <= 1'b1;
          left   <= '0;
          since  <= (since == GMAX) ? since : since + 1'b1;
        end else if (left != 5'd0) begin
          tx_bit <= shreg[0];
          shreg  <= shreg >> 1;
          left   <= left - 5'd1;
        end else tx_bit <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/async_sync_rate_conv_chk.sv
module async_sync_rate_conv_chk #(
  parameter int OSR     = 16,
  parameter int DEL_WIN = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       os_tick,
  input logic       rate_600,
  input logic       tx_bit,
  input logic       bit_stb,
  input logic [1:0] fifo_cnt,
  input logic       pop,
  input logic       del
);
  int tk;
  int pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tk <= 0;
      pc <= DEL_WIN - 1;
    end else begin
      tk <= bit_stb ? int'(os_tick) : tk + int'(os_tick);
      if (del) pc <= 0;
      else if (pop && pc < DEL_WIN) pc <= pc + 1;
    end
  end

  assert_stb_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> tk == (rate_600 ? 2 * OSR : OSR));

  assert_bit_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> $stable(tx_bit));

  assert_buf_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= 2'd2);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> fifo_cnt != 2'd0);

  assert_del_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    del |-> pc >= DEL_WIN - 1);
endmodule

bind async_sync_rate_conv async_sync_rate_conv_chk #(.OSR(OSR), .DEL_WIN(DEL_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rate_600(rate_600),
  .tx_bit(tx_bit), .bit_stb(bit_stb), .fifo_cnt(cnt), .pop(pop), .del(del)
);

// File: tb/tb_async_sync_rate_conv.sv
module tb_async_sync_rate_conv;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd_in = 1'b1;
  logic       rate_600 = 1'b0;
  logic [1:0] char_len = 2'd2;
  logic       bypass = 1'b0;
  logic       tx_bit, bit_stb;

  async_sync_rate_conv dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_in(rxd_in),
    .rate_600(rate_600), .char_len(char_len), .bypass(bypass),
    .tx_bit(tx_bit), .bit_stb(bit_stb)
  );

  int total = 0, bad = 0;
  int expq[$];
  int tdiv = 0, acc = 0;
  int tk = 0, stbn = 0;
  logic prev = 1'b1;
  int ds = 0, dcnt = 0, dval = 0, dsince = 100, ndel = 0, nins = 0, ndec = 0, brun = 0;
  bit brk_exp = 0, brk_done = 0, byp_valid = 0, byp_exp = 0, done = 0;

  function automatic int nb();
    return 8 + int'(char_len);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    os_tick <= (tdiv == 0);
  end

  always @(posedge clk) begin
    #5;
    if (!rst_n) begin
      tk = 0;
      prev = 1'b1;
    end else begin
      tk += int'(os_tick);
      if (bit_stb) begin
        chk(tk == (rate_600 ? 32 : 16), "R1 strobe period", tk, rate_600 ? 32 : 16);
        tk = 0;
        stbn++;
        if (bypass) begin
          if (byp_valid) chk(tx_bit == byp_exp, "R9 bypass bit", tx_bit, byp_exp);
        end else begin
          case (ds)
            0: if (!tx_bit) begin ds = 1; dcnt = 0; dval = 0; end
               else if (ndec > 0 && expq.size() > 0) nins++;
            1: begin
              dval |= int'(tx_bit) << dcnt;
              dcnt++;
              if (dcnt == nb() - 2) ds = 2;
            end
            2: begin
              if (brk_exp && dval == 0 && !tx_bit) begin
                ds = 3;
                brun = nb();
              end else begin
                if (expq.size() == 0) chk(0, "R4 unexpected char", dval, -1);
                else begin
                  int e;
                  e = expq.pop_front();
                  chk(dval == e, "R4 char data", dval, e);
                end
                ndec++;
                dsince++;
                if (!tx_bit) begin
                  chk(dsince >= 8, "R7 deletion spacing", dsince, 8);
                  ndel++;
                  dsince = 0;
                  ds = 1; dcnt = 0; dval = 0;
                end else ds = 0;
              end
            end
            default: if (!tx_bit) brun++;
              else begin
                chk(brun == 2 * nb() + 3, "R8 break length", brun, 2 * nb() + 3);
                brk_exp = 0;
                brk_done = 1;
                ds = 0;
              end
          endcase
        end
      end else if (tx_bit !== prev) chk(0, "R1 bit changed without strobe", tx_bit, prev);
      prev = tx_bit;
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  task automatic do_reset(input logic r6, input logic [1:0] cl, input logic byp);
    @(negedge clk);
    rst_n = 1'b0;
    rate_600 = r6; char_len = cl; bypass = byp; rxd_in = 1'b1;
    expq.delete();
    ds = 0; dsince = 100; ndel = 0; nins = 0; ndec = 0;
    brk_exp = 0; brk_done = 0; byp_valid = 0; acc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_bit(input logic v, input int per);
    rxd_in = v;
    acc += per;
    while (acc >= 100) begin
      @(negedge clk);
      acc -= 100;
    end
  endtask

  task automatic send_char(input int d, input int per);
    expq.push_back(d);
    drive_bit(1'b0, per);
    for (int i = 0; i < nb() - 2; i++) drive_bit(1'(d >> i), per);
    drive_bit(1'b1, per);
  endtask

  task automatic stream(input int n, input int per, input int seed);
    int m;
    m = (1 << (nb() - 2)) - 1;
    for (int i = 0; i < n; i++) send_char((i * 37 + seed) & m, per);
  endtask

  task automatic drain();
    for (int i = 0; i < 8000 && !(expq.size() == 0 && ds == 0); i++) @(negedge clk);
    repeat (300) @(negedge clk);
  endtask

  initial begin
    do_reset(1'b0, 2'd3, 1'b0);
    repeat (6) @(negedge clk);
    chk(tx_bit == 1'b1, "R2 reset tx_bit", tx_bit, 1);
    chk(bit_stb == 1'b0, "R2 reset strobe", bit_stb, 0);
    drive_bit(1'b0, 1200);
    drive_bit(1'b1, 12800);
    chk(ndec == 0 && tx_bit == 1'b1, "R3 glitch ignored, R2 idle marks", ndec, 0);
    stream(12, 6400, 11);
    drain();
    chk(ndec == 12, "R3 nominal char count", ndec, 12);
    chk(expq.size() == 0, "R5 nominal all delivered", expq.size(), 0);

    do_reset(1'b0, 2'd2, 1'b0);
    stream(40, 6336, 5);
    drain();
    chk(ndec == 40 && expq.size() == 0, "R5 fast all delivered", ndec, 40);
    chk(ndel >= 1, "R7 fast stop deletion seen", ndel, 1);

    do_reset(1'b0, 2'd0, 1'b0);
    stream(16, 6560, 3);
    drain();
    chk(ndec == 16 && expq.size() == 0, "R5 slow all delivered", ndec, 16);
    chk(nins >= 1, "R6 slow extra marks", nins, 1);

    do_reset(1'b1, 2'd1, 1'b0);
    stream(8, 12800, 7);
    drain();
    chk(ndec == 8 && expq.size() == 0, "R4 600 bit/s chars", ndec, 8);

    do_reset(1'b0, 2'd2, 1'b0);
    brk_exp = 1;
    drive_bit(1'b0, 6400 * 11);
    drive_bit(1'b1, 6400 * 2);
    send_char(8'hA5, 6400);
    drain();
    chk(brk_done, "R8 break stretched", brk_done, 1);
    chk(ndec == 1 && expq.size() == 0, "R8 no char after break", ndec, 1);

    do_reset(1'b0, 2'd2, 1'b1);
    for (int i = 0; i < 12; i++) begin
      int s;
      s = stbn;
      wait (stbn != s);
      repeat (32) @(negedge clk);
      rxd_in = ((i % 3) == 1);
      byp_exp = ((i % 3) == 1);
      byp_valid = 1;
    end
    repeat (80) @(negedge clk);
    chk(ndec == 0, "R9 bypass no framing", ndec, 0);
    finish_up();
  end
endmodule